// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block serializes one stereo pair of 24-bit two's complement samples per frame onto a single serial data line, MSB first. The bit clock and frame clock can come from outside (slave) or be made inside (master). In slave mode the external clocks are oversampled by the system clock and resynchronized. In master mode the block divides the system clock to make a bit clock with 64 bit clocks per frame, and a frame clock that changes on the falling edge of the bit clock.

A 2-bit framing select picks LSB-justified, MSB-justified or I2S-compatible placement of the word in each half frame. A separate 2-bit length select cuts the sample to 16, 18, 20 or 24 bits. An optional dither adds one pseudo-random LSB at the chosen length, saturating at full-scale positive. Both samples are captured together at the start of each left half, so the host may change its sample inputs at any other time. The configuration inputs are only changed while reset is held.

Top module: `audio_ser_tx`

## Requirements
- R1: While `rst` is high the block drives `sdata` low, `bclk_out` low and `lrck_out` at the right-channel level. The right-channel level is low for framing codes 00, 01 and 10, and high for code 11.
- R2: With `master_en` high, `bclk_out` has a period of 2*BCLK_HALF clock cycles and each frame clock half lasts exactly 32 bit clocks. `lrck_out` changes only in the cycle in which `bclk_out` falls. The left half is high for codes 00/10 and low for code 11.
- R3: `sdata` changes only on a falling bit clock edge and is read by the receiver on the rising edge.
- R4: Framing code 10 (MSB-justified) sends the word MSB first, starting with the first bit clock of the half. All later bit slots in that half are driven low.
- R5: Framing code 11 (I2S-compatible) sends the MSB in the second bit slot of the half, one bit clock after the frame clock edge. The rest of the half is low.
- R6: Framing code 00 (LSB-justified) places the word so that its LSB is the last of the 32 bit slots of the half. The earlier slots are low.
- R7: Length code 00/01/10/11 selects 16/18/20/24 bits. The sample is truncated by dropping its low bits.
- R8: With `dither_en` high, one LSB is added to the left word when bit 0 of a 16-bit LFSR is 1, and to the right word when bit 1 is 1. The LFSR is a right-shifting Galois register, XOR mask 0xB400 on a shifted-out 1, seed 0xACE1 at reset. It advances once at every left-half start, after its value for that frame has been used.
- R9: Dither never wraps: a truncated word already at the largest positive value is left unchanged.
- R10: With `dither_en` low the output word is the truncated sample, including at full-scale values.
- R11: Framing code 01 is reserved and keeps `sdata` low in every bit slot.
- R12: With `master_en` low the block follows `bclk_in`/`lrck_in`. It works at any even frame length, provided the half covers the word: W bits for MSB-justified, W+1 for I2S-compatible, and exactly 64 bit clocks per frame for LSB-justified.
- R13: `left_smp` and `right_smp` are sampled together at the falling bit clock that starts the left half. A change at any other time does not affect the frame already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: generate bit and frame clocks, 0: follow external clocks |
| fmt_sel | input | 2 | Framing: 00 LSB-justified, 01 reserved, 10 MSB-justified, 11 I2S-compatible |
| wlen_sel | input | 2 | Word length: 00 16, 01 18, 10 20, 11 24 bits |
| dither_en | input | 1 | Add LFSR dither at the selected LSB |
| left_smp | input | 24 | Left sample, two's complement |
| right_smp | input | 24 | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave) |
| lrck_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master), low in slave |
| lrck_out | output | 1 | Generated frame clock (master), right level in slave |
| sdata | output | 1 | Serial data output |

## Verification
Random full-range samples go through every framing code in both clock modes, and every word length appears at least once. This shows where the word sits in the half and how many low bits are cut. Full-scale positive and negative values, with dither on and off, show whether the dither saturates, wraps or appears when disabled. Slave runs at 32, 48 and 64 bit clocks per frame check that the serializer tracks the external frame length rather than a fixed count. A run that rewrites the sample inputs in the middle of the left half shows whether capture happens only at the frame start.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    FMT_LSBJ = 2'b00,
    FMT_RSVD = 2'b01,
    FMT_MSBJ = 2'b10,
    FMT_I2S  = 2'b11
  } frame_fmt_e;

  // data bits carried for a length select code
  function automatic int word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

  // frame clock level that marks the right channel
  function automatic logic right_level(input frame_fmt_e f);
    return (f == FMT_I2S);
  endfunction

endpackage

// File: rtl/sat_clocking.sv
module sat_clocking
  import sat_pkg::*;
#(
  parameter int BCLK_HALF = 2,
  parameter int HALF_BITS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master,
  input  frame_fmt_e fmt,
  input  logic       bclk_in,
  input  logic       lrck_in,
  output logic       bclk_out,
  output logic       lrck_out,
  output logic       fall,
  output logic       lr_lvl
);

  localparam int FRAME = 2 * HALF_BITS;
  localparam int CNT_W = $clog2(FRAME);
  localparam int DIV_W = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;

  // slave path: two-stage resynchronizers and edge history
  logic [1:0] bsync, lsync;
  logic       bprev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bsync <= '0;
      lsync <= '0;
      bprev <= 1'b0;
    end else begin
      bsync <= {bsync[0], bclk_in};
      lsync <= {lsync[0], lrck_in};
      bprev <= bsync[1];
    end
  end

  // master path: divider, bit counter, frame clock
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             bq, lq, tick, m_fall, lr_nx, rlev;

  always_comb begin
    rlev   = right_level(fmt);
    tick   = master && (div == DIV_W'(BCLK_HALF - 1));
    m_fall = tick & bq;
    cnt_nx = cnt + 1'b1;
    lr_nx  = (cnt_nx < CNT_W'(HALF_BITS)) ? ~rlev : rlev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= '0;
      bq  <= 1'b0;
      lq  <= rlev;
      cnt <= '1;
    end else if (master) begin
      if (tick) begin
        div <= '0;
        bq  <= ~bq;
        if (bq) begin
          cnt <= cnt_nx;
          lq  <= lr_nx;
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assign bclk_out = bq;
  assign lrck_out = lq;
  assign fall     = master ? m_fall : (bprev & ~bsync[1]);
  assign lr_lvl   = master ? lr_nx  : lsync[1];

  // R2
  lrck_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lq) |-> $fell(bq));

endmodule

// File: rtl/sat_dither.sv
module sat_dither #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] SEED   = 16'hACE1,
  parameter logic [15:0] TAPS   = 16'hB400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  output logic [1:0] dbits
);

  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LFSR_W'(SEED);
    end else if (step) begin
      state <= state[0] ? ((state >> 1) ^ LFSR_W'(TAPS)) : (state >> 1);
    end
  end

  assign dbits = state[1:0];

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state) != 0);

endmodule

// File: rtl/sat_shaper.sv
module sat_shaper
  import sat_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [1:0]       wsel,
  input  logic             dith,
  output logic [SMP_W-1:0] word
);

  int               wl, drop;
  logic [SMP_W-1:0] lsb1, keep, trunc, maxp;

  always_comb begin
    wl    = word_bits(wsel);
    drop  = SMP_W - wl;
    lsb1  = {{(SMP_W-1){1'b0}}, 1'b1} << drop;
    keep  = ~(lsb1 - 1'b1);
    trunc = smp & keep;
    maxp  = {1'b0, {(SMP_W-1){1'b1}}} & keep;
    word  = (dith && (trunc != maxp)) ? (trunc + lsb1) : trunc;
  end

  // R9
  always_comb begin
    no_wrap_chk: assert (trunc[SMP_W-1] || !word[SMP_W-1]);
  end

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
  import sat_pkg::*;
#(
  parameter int SMP_W     = 24,
  parameter int HALF_BITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             lr_lvl,
  input  frame_fmt_e       fmt,
  input  logic [1:0]       wsel,
  input  logic [SMP_W-1:0] new_l,
  input  logic [SMP_W-1:0] new_r,
  output logic             sdata,
  output logic             fstart
);

  localparam int POS_W = $clog2(2 * HALF_BITS) + 1;

  logic             lr_prev, in_left, rlev, changed, start, left_now, bit_v;
  logic [POS_W-1:0] pos, p_eff;
  logic [SMP_W-1:0] cur_l, cur_r, word, shifted;
  int               wl, k;

  always_comb begin
    rlev     = right_level(fmt);
    changed  = fall && (lr_lvl != lr_prev);
    start    = changed && (lr_lvl != rlev);
    p_eff    = changed ? '0 : ((pos == '1) ? pos : pos + 1'b1);
    left_now = changed ? (lr_lvl != rlev) : in_left;
    word     = left_now ? (start ? new_l : cur_l) : cur_r;
    wl       = word_bits(wsel);
    case (fmt)
      FMT_MSBJ: k = int'(p_eff);
      FMT_I2S:  k = int'(p_eff) - 1;
      FMT_LSBJ: k = int'(p_eff) - (HALF_BITS - wl);
      default:  k = -1;
    endcase
    if (k >= 0 && k < wl) begin
      shifted = word << k;
      bit_v   = shifted[SMP_W-1];
    end else begin
      shifted = '0;
      bit_v   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev <= rlev;
      in_left <= 1'b0;
      pos     <= '0;
      cur_l   <= '0;
      cur_r   <= '0;
      sdata   <= 1'b0;
    end else if (fall) begin
      lr_prev <= lr_lvl;
      pos     <= p_eff;
      in_left <= left_now;
      sdata   <= bit_v;
      if (start) begin
        cur_l <= new_l;
        cur_r <= new_r;
      end
    end
  end

  assign fstart = start;

  // R11
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt == FMT_RSVD) |=> !sdata);

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import sat_pkg::*;
#(
  parameter int          SMP_W     = 24,
  parameter int          HALF_BITS = 32,
  parameter int          BCLK_HALF = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       wlen_sel,
  input  logic             dither_en,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  input  logic             bclk_in,
  input  logic             lrck_in,
  output logic             bclk_out,
  output logic             lrck_out,
  output logic             sdata
);

  frame_fmt_e       fmt;
  logic             fall, lr_lvl, fstart;
  logic [1:0]       dbits;
  logic [SMP_W-1:0] word_l, word_r;

  assign fmt = frame_fmt_e'(fmt_sel);

  sat_clocking #(.BCLK_HALF(BCLK_HALF), .HALF_BITS(HALF_BITS)) u_clk (
    .clk(clk), .rst(rst), .master(master_en), .fmt(fmt),
    .bclk_in(bclk_in), .lrck_in(lrck_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out),
    .fall(fall), .lr_lvl(lr_lvl)
  );

  sat_dither #(.SEED(LFSR_SEED)) u_dith (
    .clk(clk), .rst(rst), .step(fstart), .dbits(dbits)
  );

  sat_shaper #(.SMP_W(SMP_W)) u_shp_l (
    .smp(left_smp), .wsel(wlen_sel), .dith(dither_en & dbits[0]), .word(word_l)
  );

  sat_shaper #(.SMP_W(SMP_W)) u_shp_r (
    .smp(right_smp), .wsel(wlen_sel), .dith(dither_en & dbits[1]), .word(word_r)
  );

  sat_serializer #(.SMP_W(SMP_W), .HALF_BITS(HALF_BITS)) u_ser (
    .clk(clk), .rst(rst), .fall(fall), .lr_lvl(lr_lvl), .fmt(fmt),
    .wsel(wlen_sel), .new_l(word_l), .new_r(word_r),
    .sdata(sdata), .fstart(fstart)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sdata);

  // R3
  data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && !$stable(sdata)) |-> $fell(bclk_out));

endmodule

// File: tb/sim_audio_ser_tx.sv
module sim_audio_ser_tx;

  localparam int BH = 2;
  localparam int SH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_en = 1'b1;
  logic [1:0]  fmt_sel = 2'b10, wlen_sel = 2'b11;
  logic        dither_en = 1'b0;
  logic [23:0] left_smp = '0, right_smp = '0;
  logic        bclk_in = 1'b1, lrck_in = 1'b0;
  logic        bclk_out, lrck_out, sdata;

  always #10 clk = ~clk;

  audio_ser_tx #(.BCLK_HALF(BH)) u0 (
    .clk(clk), .rst(rst), .master_en(master_en), .fmt_sel(fmt_sel),
    .wlen_sel(wlen_sel), .dither_en(dither_en), .left_smp(left_smp),
    .right_smp(right_smp), .bclk_in(bclk_in), .lrck_in(lrck_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out), .sdata(sdata)
  );

  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 18 : (c == 2'b10) ? 20 : 24;
  endfunction

  // right-aligned expected word after truncation and dither
  function automatic logic [23:0] proc(input logic [23:0] s, input int wl, input logic d);
    int sv, t, maxp;
    sv   = int'($signed(s));
    t    = sv >>> (24 - wl);
    maxp = (1 << (wl - 1)) - 1;
    if (d && t != maxp) t = t + 1;
    return 24'(t);
  endfunction

  function automatic logic [15:0] lf_step(input logic [15:0] s);
    logic fb;
    fb = s[0];
    s  = s >> 1;
    if (fb) s = s ^ 16'hB400;
    return s;
  endfunction

  function automatic logic [63:0] exp_half(input logic [1:0] f, input int wl,
                                           input logic [23:0] v, input int h);
    logic [63:0] r;
    int k;
    r = '0;
    for (int p = 0; p < h; p++) begin
      case (f)
        2'b10:   k = p;
        2'b11:   k = p - 1;
        2'b00:   k = p - (32 - wl);
        default: k = -1;
      endcase
      if (k >= 0 && k < wl) r[p] = v[wl - 1 - k];
    end
    return r;
  endfunction

  // phase state
  logic        rl, mb_last, sd_last, lo_last, tflag, have_rise;
  longint      last_rise;
  int          fbits, sc;
  logic [23:0] pl, pr;

  task automatic new_samples(input int mode);
    if (mode == 1) begin
      pl = 24'h7FFFFF;
      pr = ($urandom % 2 == 0) ? 24'h7FFFFF : 24'h800000;
    end else begin
      pl = 24'($urandom);
      pr = 24'($urandom);
    end
    left_smp  = pl;
    right_smp = pr;
  endtask

  task automatic do_reset(input logic m, input logic [1:0] f, input logic [1:0] w, input logic d);
    @(negedge clk);
    rst       = 1'b1;
    master_en = m;
    fmt_sel   = f;
    wlen_sel  = w;
    dither_en = d;
    rl        = (f == 2'b11);
    bclk_in   = 1'b1;
    lrck_in   = rl;
    repeat (3) @(negedge clk);
    // R1: idle outputs in reset
    check("R1 reset outputs", {61'd0, sdata, bclk_out, lrck_out}, {61'd0, 1'b0, 1'b0, rl});
    rst = 1'b0;
    repeat (4) @(negedge clk);
    mb_last   = bclk_out;
    sd_last   = sdata;
    lo_last   = lrck_out;
    have_rise = 1'b0;
    tflag     = 1'b0;
    sc        = 0;
  endtask

  task automatic next_bit(output logic b, output logic lr);
    if (master_en) begin
      forever begin
        @(negedge clk);
        if (sdata !== sd_last && !(mb_last && !bclk_out)) tflag = 1'b1;
        if (lrck_out !== lo_last && !(mb_last && !bclk_out)) tflag = 1'b1;
        sd_last = sdata;
        lo_last = lrck_out;
        if (bclk_out && !mb_last) begin
          mb_last = 1'b1;
          if (have_rise && (cyc - last_rise) != 2 * BH) tflag = 1'b1;
          have_rise = 1'b1;
          last_rise = cyc;
          b  = sdata;
          lr = lrck_out;
          break;
        end
        mb_last = bclk_out;
      end
    end else begin
      lrck_in = (sc < fbits / 2) ? ~rl : rl;
      bclk_in = 1'b0;
      repeat (SH) @(negedge clk);
      bclk_in = 1'b1;
      b  = sdata;
      lr = lrck_in;
      repeat (SH) @(negedge clk);
      sc = (sc + 1) % fbits;
    end
  endtask

  task automatic run_phase(input string tag, input logic m, input logic [1:0] f,
                           input logic [1:0] w, input logic d, input int mode,
                           input int nfr, input int fb);
    logic [15:0] lf;
    logic [63:0] gl, gr, mask;
    logic [23:0] evl, evr;
    logic        prev_lr, started, in_l, b, lr;
    int          frames, pos, h, wl, ln_l, ln_r;
    fbits = fb;
    wl    = wbits(w);
    new_samples(mode);
    do_reset(m, f, w, d);
    lf = 16'hACE1; prev_lr = rl; started = 1'b0; in_l = 1'b0;
    frames = 0; pos = 0; ln_l = 0; ln_r = 0; gl = '0; gr = '0;
    evl = '0; evr = '0;
    h    = m ? 32 : fb / 2;
    mask = (64'd1 << h) - 64'd1;
    while (frames < nfr) begin
      next_bit(b, lr);
      if (lr !== prev_lr) begin
        if (lr !== rl) begin
          if (started) begin
            check({tag, " left word"},  gl & mask, exp_half(f, wl, evl, h));
            check({tag, " right word"}, gr & mask, exp_half(f, wl, evr, h));
            if (m) begin
              // R2 half length, R3 edge discipline
              check("R2 half lengths", {32'(ln_l), 32'(ln_r)}, {32'd32, 32'd32});
              check("R3 edges and period", {63'd0, tflag}, 64'd0);
            end
            frames++;
          end
          tflag   = 1'b0;
          started = 1'b1;
          evl = proc(pl, wl, d & lf[0]);
          evr = proc(pr, wl, d & lf[1]);
          lf  = lf_step(lf);
          new_samples(mode);
          gl = '0; gr = '0; in_l = 1'b1;
        end else begin
          in_l = 1'b0;
        end
        pos = 0;
      end else begin
        pos++;
      end
      prev_lr = lr;
      if (started && pos < 64) begin
        if (in_l) begin gl[pos] = b; ln_l = pos + 1; end
        else      begin gr[pos] = b; ln_r = pos + 1; end
      end
      // R13: rewrite inputs mid-frame
      if (mode == 2 && in_l && pos == 10) new_samples(0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    run_phase("R4 msb 24",         1'b1, 2'b10, 2'b11, 1'b0, 0, 5, 64);
    run_phase("R5 i2s 16",         1'b1, 2'b11, 2'b00, 1'b0, 0, 5, 64);
    run_phase("R6 lsb 20",         1'b1, 2'b00, 2'b10, 1'b0, 0, 5, 64);
    run_phase("R7 msb 18",         1'b1, 2'b10, 2'b01, 1'b0, 0, 5, 64);
    run_phase("R8 i2s 20 dither",  1'b1, 2'b11, 2'b10, 1'b1, 0, 8, 64);
    run_phase("R9 lsb 24 sat",     1'b1, 2'b00, 2'b11, 1'b1, 1, 6, 64);
    run_phase("R10 msb 16 nodith", 1'b1, 2'b10, 2'b00, 1'b0, 1, 4, 64);
    run_phase("R11 reserved",      1'b1, 2'b01, 2'b11, 1'b1, 0, 4, 64);
    run_phase("R12 slave msb 48",  1'b0, 2'b10, 2'b11, 1'b0, 0, 4, 48);
    run_phase("R12 slave msb 32",  1'b0, 2'b10, 2'b00, 1'b1, 0, 4, 32);
    run_phase("R12 slave i2s 48",  1'b0, 2'b11, 2'b00, 1'b0, 0, 4, 48);
    run_phase("R12 slave lsb 64",  1'b0, 2'b00, 2'b10, 1'b1, 0, 4, 64);
    run_phase("R13 capture",       1'b1, 2'b10, 2'b11, 1'b0, 2, 5, 64);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule